// File: doc/BRIEF.md
# Sixteen-Channel Edge-Programmed PWM Generator

This block drives sixteen PWM outputs from one shared timebase. A prescaler turns the input clock into step ticks, and a step counter built on those ticks sets the common period. Each channel has two step positions of its own. Its output goes high at the rise position and low at the fall position, so the duty and the phase of each channel are both set by two numbers. Channels whose edges must change cleanly can be placed in a synchronized-update group. Edge writes for those channels wait in shadow storage until software arms a transfer. The new values then take effect together at the next period boundary.

The block is programmed through a plain synchronous write/read port with a 6-bit address and 8-bit data. The address map is: 0x00 prescale, 0x01 period steps, 0x02/0x03 enables, 0x04/0x05 synchronized-update mask, 0x06 transfer arm, and 0x20 + 2·ch / 0x21 + 2·ch for the rise and fall edges of channel ch. The block has no bus bridge and no interrupts.

Top module: `edge_pwm_array`

## Requirements
- R1: After reset every register reads 0, every channel is disabled, all sixteen outputs are low and rdData is 0.
- R2: A step lasts prescale+1 clocks (register 0x00) and a period lasts periodSteps+1 steps (register 0x01). A prescale or step count that is at or above its limit ends the step or the period, and all channels share this one timebase.
- R3: On the first clock of each step, an enabled channel compares the step count with its active edges. It drives its output high on a rise match and low on a fall match, and the output register shows the result one clock later. The output changes at no other time.
- R4: When rise equals fall and the step count matches them, the output inverts. This happens once per period, so the channel gives a 50% square wave at twice the period.
- R5: An edge value the step counter never reaches never acts. A fall of periodSteps+1 with a rise of 0 gives a constant high. A rise of periodSteps+1 with a fall of 0 gives a constant low.
- R6: Register 0x02 enables channels 0–7 and register 0x03 enables channels 8–15, each at bit (ch mod 8). An enable value becomes active only at a period boundary. While a channel is inactive its output is low.
- R7: For a channel whose mask bit is 0, an edge write at 0x20+2·ch (rise) or 0x21+2·ch (fall) goes to both the shadow and the active register. The new value is used from the next step start. The mask bit is bit (ch mod 8) of 0x04 for channels 0–7 and of 0x05 for channels 8–15.
- R8: For a masked channel, an edge write changes only the shadow. Writing a value with bit 0 set to 0x06 arms a transfer. At the next period boundary all shadow edges are copied to the active edges and the arm clears, so later masked writes wait for a new arm.
- R9: A read returns the shadow register contents on rdData one clock after rdEn. Address 0x06 and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 6 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |
| pwmOut | output | 16 | Channel outputs |

## Verification
The hardest situation to reach from the ports is a masked channel whose shadow edges differ from its active edges, held over several periods and then committed on one exact boundary. In the same run the transfer must clear itself, so that a later masked write stays pending. The stimulus first reads back the shadow to show the pending value while the output keeps its old duty. It then arms the transfer and measures the new duty. Finally it writes the shadow again without arming and confirms the duty does not move. A behavioural reference model checks every clock, so a transfer that lands one step early or late is caught.

// File: rtl/edge_pwm_pkg.sv
package edge_pwm_pkg;
  localparam int NUM_CH = 16;
  localparam int STEP_W = 8;
  localparam int ADDR_W = 6;
  localparam int CH_W   = $clog2(NUM_CH);

  // Strobes from the register control to the datapath
  typedef struct packed {
    logic              edgeWr;
    logic              edgeDirect;
    logic              edgeIsFall;
    logic [CH_W-1:0]   edgeCh;
    logic [STEP_W-1:0] edgeData;
    logic              commitArm;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_regs_ctrl.sv
module pwm_regs_ctrl
  import edge_pwm_pkg::*;
#(
  parameter int NumCh = NUM_CH,
  parameter int StepW = STEP_W,
  parameter int AddrW = ADDR_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [AddrW-1:0]            addr,
  input  logic [StepW-1:0]            wrData,
  output logic [StepW-1:0]            rdData,
  input  logic                        periodEnd,
  output pwmStrobe_t                  strb,
  output logic [StepW-1:0]            prescale,
  output logic [StepW-1:0]            periodSteps,
  output logic [NumCh-1:0]            enableVec,
  output logic [NumCh-1:0][StepW-1:0] shRise,
  output logic [NumCh-1:0][StepW-1:0] shFall
);
  localparam int ChW      = $clog2(NumCh);
  localparam int EnBytes  = NumCh / 8;
  localparam int EnBase   = 2;
  localparam int MaskBase = EnBase + EnBytes;
  localparam int SyncAddr = MaskBase + EnBytes;
  localparam logic [AddrW-1:0] EdgeBase = AddrW'(1 << (ChW + 1));

  logic [NumCh-1:0] syncMask;
  logic             armed;
  logic             isEdge;
  logic [ChW-1:0]   edgeCh;
  logic             edgeFall;
  logic [StepW-1:0] readVal;

  assign isEdge   = addr[AddrW-1:ChW+1] == EdgeBase[AddrW-1:ChW+1];
  assign edgeCh   = addr[ChW:1];
  assign edgeFall = addr[0];

  always_comb begin
    readVal = '0;
    if (addr == AddrW'(0)) readVal = prescale;
    if (addr == AddrW'(1)) readVal = periodSteps;
    for (int b = 0; b < EnBytes; b++) begin
      if (addr == AddrW'(EnBase + b))   readVal = enableVec[b*8 +: 8];
      if (addr == AddrW'(MaskBase + b)) readVal = syncMask[b*8 +: 8];
    end
    if (isEdge) readVal = edgeFall ? shFall[edgeCh] : shRise[edgeCh];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData      <= '0;
      prescale    <= '0;
      periodSteps <= '0;
      enableVec   <= '0;
      syncMask    <= '0;
      shRise      <= '0;
      shFall      <= '0;
      armed       <= 1'b0;
    end else begin
      if (rdEn) rdData <= readVal;
      if (wrEn) begin
        if (addr == AddrW'(0)) prescale    <= wrData;
        if (addr == AddrW'(1)) periodSteps <= wrData;
        for (int b = 0; b < EnBytes; b++) begin
          if (addr == AddrW'(EnBase + b))   enableVec[b*8 +: 8] <= wrData;
          if (addr == AddrW'(MaskBase + b)) syncMask[b*8 +: 8]  <= wrData;
        end
        if (isEdge) begin
          if (edgeFall) shFall[edgeCh] <= wrData;
          else          shRise[edgeCh] <= wrData;
        end
      end
      if (wrEn && addr == AddrW'(SyncAddr) && wrData[0]) armed <= 1'b1;
      else if (periodEnd)                                armed <= 1'b0;
    end
  end

  assign strb.edgeWr     = wrEn && isEdge;
  assign strb.edgeDirect = !syncMask[edgeCh];
  assign strb.edgeIsFall = edgeFall;
  assign strb.edgeCh     = edgeCh;
  assign strb.edgeData   = wrData;
  assign strb.commitArm  = armed;
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import edge_pwm_pkg::*;
#(
  parameter int NumCh = NUM_CH,
  parameter int StepW = STEP_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pwmStrobe_t                  strb,
  input  logic [StepW-1:0]            prescale,
  input  logic [StepW-1:0]            periodSteps,
  input  logic [NumCh-1:0]            enableVec,
  input  logic [NumCh-1:0][StepW-1:0] shRise,
  input  logic [NumCh-1:0][StepW-1:0] shFall,
  output logic [NumCh-1:0]            pwmOut,
  output logic [NumCh-1:0]            actEn,
  output logic                        periodEnd,
  output logic                        stepStart
);
  localparam int ChW = $clog2(NumCh);

  logic [StepW-1:0] preCnt;
  logic [StepW-1:0] stepCnt;
  logic             stepTick;
  logic             doCommit;

  assign stepTick  = preCnt >= prescale;
  assign periodEnd = stepTick && (stepCnt >= periodSteps);
  assign stepStart = preCnt == '0;
  assign doCommit  = periodEnd && strb.commitArm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      stepCnt <= '0;
      actEn   <= '0;
    end else begin
      if (stepTick) begin
        preCnt  <= '0;
        stepCnt <= periodEnd ? '0 : stepCnt + 1'b1;
      end else begin
        preCnt  <= preCnt + 1'b1;
      end
      if (periodEnd) actEn <= enableVec;
    end
  end

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    logic [StepW-1:0] actRise;
    logic [StepW-1:0] actFall;
    logic             chOut;
    logic             chSel;
    logic             hitRise;
    logic             hitFall;

    assign chSel   = strb.edgeWr && strb.edgeDirect && (strb.edgeCh == ChW'(c));
    assign hitRise = stepCnt == actRise;
    assign hitFall = stepCnt == actFall;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actRise <= '0;
        actFall <= '0;
        chOut   <= 1'b0;
      end else begin
        if (chSel && !strb.edgeIsFall) actRise <= strb.edgeData;
        else if (doCommit)             actRise <= shRise[c];
        if (chSel && strb.edgeIsFall)  actFall <= strb.edgeData;
        else if (doCommit)             actFall <= shFall[c];
        if (!actEn[c]) begin
          chOut <= 1'b0;
        end else if (stepStart) begin
          if (hitRise && hitFall) chOut <= ~chOut;
          else if (hitRise)       chOut <= 1'b1;
          else if (hitFall)       chOut <= 1'b0;
        end
      end
    end

    assign pwmOut[c] = chOut;
  end
endmodule

// File: rtl/edge_pwm_array.sv
module edge_pwm_array
  import edge_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STEP_W-1:0] wrData,
  output logic [STEP_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  pwmStrobe_t                    strb;
  logic [STEP_W-1:0]             prescale;
  logic [STEP_W-1:0]             periodSteps;
  logic [NUM_CH-1:0]             enableVec;
  logic [NUM_CH-1:0][STEP_W-1:0] shRise;
  logic [NUM_CH-1:0][STEP_W-1:0] shFall;
  logic [NUM_CH-1:0]             actEn;
  logic                          periodEnd;
  logic                          stepStart;

  pwm_regs_ctrl #(.NumCh(NUM_CH), .StepW(STEP_W), .AddrW(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .periodEnd(periodEnd), .strb(strb),
    .prescale(prescale), .periodSteps(periodSteps), .enableVec(enableVec),
    .shRise(shRise), .shFall(shFall)
  );

  pwm_datapath #(.NumCh(NUM_CH), .StepW(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .prescale(prescale),
    .periodSteps(periodSteps), .enableVec(enableVec), .shRise(shRise),
    .shFall(shFall), .pwmOut(pwmOut), .actEn(actEn),
    .periodEnd(periodEnd), .stepStart(stepStart)
  );
endmodule

// File: rtl/edge_pwm_chk.sv
module edge_pwm_chk #(
  parameter int NumCh = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [NumCh-1:0] pwmOut,
  input logic [NumCh-1:0] actEn,
  input logic             stepStart,
  input logic             periodEnd
);
  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actEn != {NumCh{1'b1}}) |=> ((pwmOut & ~$past(actEn)) == '0));

  // R6
  enable_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd |=> $stable(actEn));

  // R3
  out_at_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepStart |=> (((pwmOut ^ $past(pwmOut)) & $past(actEn)) == '0));

  // R2
  period_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> stepStart);
endmodule

bind edge_pwm_array edge_pwm_chk #(.NumCh(edge_pwm_pkg::NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .actEn(actEn),
  .stepStart(stepStart), .periodEnd(periodEnd)
);

// File: tb/edge_pwm_array_tb.sv
module edge_pwm_array_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [15:0] pwmOut;

  always #10 clk = ~clk;

  edge_pwm_array u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  int    total = 0;
  int    fails = 0;
  bit    checking = 1'b0;
  string phaseTag = "R1";

  // Reference model state
  int         mPre, mStep;
  logic [7:0] mPresc, mPer, mRd;
  logic [15:0] mEn, mActEn, mMask, mOut;
  bit         mArmed;
  logic [7:0] mShR[16], mShF[16], mActR[16], mActF[16];

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(logic [5:0] a);
    logic [7:0] v = 8'h00;
    case (a)
      6'h00: v = mPresc;
      6'h01: v = mPer;
      6'h02: v = mEn[7:0];
      6'h03: v = mEn[15:8];
      6'h04: v = mMask[7:0];
      6'h05: v = mMask[15:8];
      default: if (a[5]) v = a[0] ? mShF[a[4:1]] : mShR[a[4:1]];
    endcase
    return v;
  endfunction

  always @(posedge clk) begin : refModel
    bit ss, tick, pe, r, f;
    logic [15:0] nOut;
    if (!rstN) begin
      mPre = 0; mStep = 0; mPresc = 0; mPer = 0; mRd = 0;
      mEn = 0; mActEn = 0; mMask = 0; mOut = 0; mArmed = 0;
      for (int c = 0; c < 16; c++) begin
        mShR[c] = 0; mShF[c] = 0; mActR[c] = 0; mActF[c] = 0;
      end
    end else begin
      ss   = (mPre == 0);
      tick = (mPre >= int'(mPresc));
      pe   = tick && (mStep >= int'(mPer));
      nOut = mOut;
      for (int c = 0; c < 16; c++) begin
        r = (mStep == int'(mActR[c]));
        f = (mStep == int'(mActF[c]));
        if (!mActEn[c]) nOut[c] = 1'b0;
        else if (ss) begin
          if (r && f) nOut[c] = !mOut[c];
          else if (r) nOut[c] = 1'b1;
          else if (f) nOut[c] = 1'b0;
        end
      end
      if (rdEn) mRd = modelRead(addr);
      if (pe) begin
        mActEn = mEn;
        if (mArmed)
          for (int c = 0; c < 16; c++) begin
            mActR[c] = mShR[c]; mActF[c] = mShF[c];
          end
        mArmed = 0;
      end
      if (tick) begin
        mPre = 0;
        mStep = pe ? 0 : mStep + 1;
      end else mPre = mPre + 1;
      if (wrEn) begin
        case (addr)
          6'h00: mPresc = wrData;
          6'h01: mPer = wrData;
          6'h02: mEn[7:0] = wrData;
          6'h03: mEn[15:8] = wrData;
          6'h04: mMask[7:0] = wrData;
          6'h05: mMask[15:8] = wrData;
          6'h06: if (wrData[0]) mArmed = 1;
          default: if (addr[5]) begin
            if (addr[0]) begin
              mShF[addr[4:1]] = wrData;
              if (!mMask[addr[4:1]]) mActF[addr[4:1]] = wrData;
            end else begin
              mShR[addr[4:1]] = wrData;
              if (!mMask[addr[4:1]]) mActR[addr[4:1]] = wrData;
            end
          end
        endcase
      end
      mOut = nOut;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      check({phaseTag, " outputs vs model"}, int'(pwmOut), int'(mOut));
      check({phaseTag, " rdData vs model"}, int'(rdData), int'(mRd));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input int exp);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(req, int'(rdData), exp);
  endtask

  task automatic countHigh(input int ch, input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      cnt += int'(pwmOut[ch]);
    end
  endtask

  task automatic countRise(input int ch, input int n, output int cnt);
    logic prev;
    cnt = 0;
    @(negedge clk);
    prev = pwmOut[ch];
    repeat (n) begin
      @(negedge clk);
      if (pwmOut[ch] && !prev) cnt++;
      prev = pwmOut[ch];
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin : stimulus
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", int'(pwmOut), 0);
    check("R1 reset rdData", int'(rdData), 0);
    rstN = 1'b1;
    checking = 1'b1;
    rdChk("R1 prescale reset", 6'h00, 0);
    rdChk("R1 enable reset", 6'h02, 0);

    phaseTag = "R3";
    wr(6'h00, 8'd1);
    wr(6'h01, 8'd3);
    wr(6'h20, 8'd1); wr(6'h21, 8'd3);   // ch0 rise 1 fall 3
    wr(6'h22, 8'd2); wr(6'h23, 8'd2);   // ch1 equal edges
    wr(6'h24, 8'd0); wr(6'h25, 8'd4);   // ch2 full
    wr(6'h26, 8'd4); wr(6'h27, 8'd0);   // ch3 none
    wr(6'h28, 8'd1); wr(6'h29, 8'd2);   // ch4 left disabled
    wr(6'h32, 8'd0); wr(6'h33, 8'd4);   // ch9 full
    wr(6'h02, 8'h0F);
    wr(6'h03, 8'h02);
    idle(40);
    countHigh(0, 8, n);  check("R3 ch0 high cycles per period", n, 4);
    countRise(0, 32, n); check("R2 ch0 rising edges in 32 clocks", n, 4);
    phaseTag = "R4";
    countHigh(1, 16, n); check("R4 ch1 equal edges high cycles", n, 8);
    phaseTag = "R5";
    countHigh(2, 8, n);  check("R5 ch2 unreachable fall", n, 8);
    countHigh(3, 8, n);  check("R5 ch3 unreachable rise", n, 0);
    phaseTag = "R6";
    countHigh(4, 8, n);  check("R6 ch4 disabled low", n, 0);
    countHigh(9, 8, n);  check("R6 ch9 upper enable byte", n, 8);

    phaseTag = "R9";
    rdChk("R9 read ch0 rise", 6'h20, 1);
    rdChk("R9 read ch1 fall", 6'h23, 2);
    rdChk("R9 read upper enable", 6'h03, 2);
    rdChk("R9 read arm reg", 6'h06, 0);
    rdChk("R9 read unmapped", 6'h10, 0);

    phaseTag = "R8";
    wr(6'h04, 8'h01);
    wr(6'h20, 8'd0); wr(6'h21, 8'd4);
    rdChk("R8 shadow holds masked write", 6'h21, 4);
    idle(24);
    countHigh(0, 8, n);  check("R8 masked write pending", n, 4);
    wr(6'h06, 8'h01);
    idle(20);
    countHigh(0, 8, n);  check("R8 armed transfer applied", n, 8);
    wr(6'h21, 8'd2);
    idle(24);
    countHigh(0, 8, n);  check("R8 arm cleared after transfer", n, 8);

    phaseTag = "R7";
    wr(6'h25, 8'd2);
    idle(16);
    countHigh(2, 8, n);  check("R7 direct fall write", n, 4);

    phaseTag = "R6";
    wr(6'h03, 8'h00);
    idle(16);
    countHigh(9, 8, n);  check("R6 ch9 disabled low", n, 0);

    phaseTag = "R2";
    wr(6'h00, 8'd0);
    wr(6'h01, 8'd7);
    idle(24);
    countHigh(2, 8, n);  check("R2 new timebase ch2 duty", n, 2);
    countRise(2, 16, n); check("R2 new timebase ch2 rises", n, 2);

    checking = 1'b0;
    summary();
  end
endmodule